// File: doc/BRIEF.md
# Four-Lane Programmable Log / Antilog / Constant-Multiply Converter

This block is a single pipeline stage of four identical arithmetic lanes. One mode code, shared by every lane, turns each lane into one of three converters. The first takes a single-precision floating-point operand to a fixed-point base-2 logarithm. The second takes a fixed-point logarithm back to a single-precision value. The third multiplies a fixed-point operand by a small integer constant picked from a table by a function index. No lane has a multiplier. In every mode, a small table per lane picks shift amounts, a term generator forms shifted copies of the operand, and one adder tree per lane sums them. The same tree serves all three modes.

Log-domain numbers are signed two's complement fixed point with 8 integer bits and 24 fractional bits. Conversions use a piecewise correction. The top four fraction bits select a segment, and each segment supplies up to three right-shift amounts. The shifted copies of the fraction are then added to, or subtracted from, the linear estimate. An input is accepted on any cycle that has the valid flag set. Its four results appear one clock later. Mode and function index may change on every accepted input.

Top module: `prog_cnv`

## Requirements
- R1: The four lanes use the same mode and function index. Lane j reads bits [32j+31:32j] of the operand bus and writes the same bits of the result bus, and its result depends only on its own operand.
- R2: An input accepted at a rising edge with in_valid_i high produces out_valid_o high and its results on result_o directly after that edge. Inputs may be accepted on consecutive cycles.
- R3: At an edge where in_valid_i is low, out_valid_o goes low and result_o keeps its previous value, whatever the mode, index and operands are.
- R4: While rst_ni is low, out_valid_o and result_o are zero, and they become zero as soon as rst_ni falls. Inputs are accepted from the third rising edge after rst_ni rises.
- R5: Mode 2'b10 multiplies by a constant: result = operand × k modulo 2^32. For function index i, k is i+1 for i = 0..12, 16 for i = 13, 17 for i = 14, and 0 for i = 15. k is built as s + 2^p + 2^q, where p and q are in {1,2,3} or absent, and s is 1 exactly when k is odd.
- R6: A change of mode or function index affects exactly the input accepted with it. Alternating modes and indices on back-to-back cycles gives each result the operation it was issued with.
- R7: Mode 2'b00 (log) reads the operand as a single-precision value. Bit 31 is ignored, and the exponent field must be 1..253. The result is log2 of the magnitude in the 8.24 format, within 2^-5. For a zero mantissa field the result is exactly (exponent − 127)·2^24.
- R8: Mode 2'b01 (antilog) reads the operand as 8.24 fixed point x, with integer part floor(x) between −126 and 127. The result is a positive single-precision value with exponent field floor(x)+127, and it is within a relative error of 2^-5 of 2^x. For an integer x the mantissa field is exactly zero.
- R9: Mode 2'b11 is reserved and gives an all-zero result in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid_i | input | 1 | Accept the operands, mode and index on this edge |
| mode_i | input | 2 | 00 log, 01 antilog, 10 constant multiply, 11 reserved |
| fn_idx_i | input | 4 | Constant table index for the multiply mode |
| opnd_i | input | 128 | Four 32-bit operands, lane 0 in the low bits |
| out_valid_o | output | 1 | Result bus holds the result of the previous accepted input |
| result_o | output | 128 | Four 32-bit results, lane 0 in the low bits |

## Verification
The hardest situation to reach from the ports is the one where the shared adder tree changes its role on every cycle. This happens when a log, an antilog, a multiply and a reserved operation follow each other back to back. A result computed with a stale table selection or a stale sign of the correction terms only shows up then. The vector table is therefore streamed with the valid flag held high and the mode and index changing on every entry.

Sweeps of the log and antilog modes then give each lane a different operand. These operands spread across all sixteen correction segments and several binades, and the results are compared against a real-valued model. An exhaustive walk over the sixteen constant indices follows. It uses operands that carry into the top bit, so that dropped or misplaced shift terms become visible.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FRAC_W   = 24;
  localparam int unsigned INT_W    = WORD_W - FRAC_W;
  localparam int unsigned FP_EXP_W = 8;
  localparam int unsigned FP_MAN_W = 23;
  localparam int unsigned FP_BIAS  = 127;
  localparam int unsigned N_TERMS  = 4;
  localparam int unsigned SH_W     = 5;
  localparam int unsigned SEG_W    = 4;
  localparam int unsigned FN_W     = 4;
  localparam int unsigned KSH_W    = 2;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    CM_LOG  = 2'b00,
    CM_ALOG = 2'b01,
    CM_KMUL = 2'b10,
    CM_RSVD = 2'b11
  } cnv_mode_e;

  // Three right-shift amounts; zero disables a term.
  typedef struct packed {
    logic [SH_W-1:0] a;
    logic [SH_W-1:0] b;
    logic [SH_W-1:0] c;
  } shift_set_t;

  // Constant k = odd + 2^p + 2^q, a zero shift field removes that copy.
  typedef struct packed {
    logic             odd;
    logic [KSH_W-1:0] p;
    logic [KSH_W-1:0] q;
  } kmul_ent_t;

  // Segment slopes of log2(1+f) - f, as sums of powers of two.
  function automatic shift_set_t log_seg_lut(input logic [SEG_W-1:0] seg);
    shift_set_t r;
    case (seg)
      4'd0:  r = '{5'd2, 5'd3, 5'd5};
      4'd1:  r = '{5'd2, 5'd3, 5'd0};
      4'd2:  r = '{5'd2, 5'd4, 5'd5};
      4'd3:  r = '{5'd2, 5'd4, 5'd0};
      4'd4:  r = '{5'd2, 5'd6, 5'd8};
      4'd5:  r = '{5'd2, 5'd0, 5'd0};
      4'd6:  r = '{5'd3, 5'd4, 5'd5};
      4'd7:  r = '{5'd3, 5'd4, 5'd0};
      4'd8:  r = '{5'd3, 5'd5, 5'd0};
      4'd9:  r = '{5'd3, 5'd7, 5'd0};
      4'd10: r = '{5'd4, 5'd5, 5'd6};
      4'd11: r = '{5'd4, 5'd6, 5'd7};
      4'd12: r = '{5'd4, 5'd8, 5'd0};
      4'd13: r = '{5'd5, 5'd6, 5'd0};
      4'd14: r = '{5'd6, 5'd7, 5'd8};
      default: r = '{5'd7, 5'd10, 5'd0};
    endcase
    return r;
  endfunction

  // Segment slopes of g - (2^g - 1), subtracted from the fraction.
  function automatic shift_set_t alog_seg_lut(input logic [SEG_W-1:0] seg);
    shift_set_t r;
    case (seg)
      4'd0:  r = '{5'd2, 5'd5, 5'd6};
      4'd1:  r = '{5'd2, 5'd5, 5'd0};
      4'd2:  r = '{5'd2, 5'd6, 5'd0};
      4'd3:  r = '{5'd2, 5'd0, 5'd0};
      4'd4:  r = '{5'd2, 5'd0, 5'd0};
      4'd5:  r = '{5'd3, 5'd4, 5'd5};
      4'd6:  r = '{5'd3, 5'd4, 5'd6};
      4'd7:  r = '{5'd3, 5'd4, 5'd0};
      4'd8:  r = '{5'd3, 5'd5, 5'd7};
      4'd9:  r = '{5'd3, 5'd6, 5'd0};
      4'd10: r = '{5'd3, 5'd0, 5'd0};
      4'd11: r = '{5'd4, 5'd5, 5'd7};
      4'd12: r = '{5'd4, 5'd6, 5'd9};
      4'd13: r = '{5'd5, 5'd6, 5'd7};
      4'd14: r = '{5'd5, 5'd8, 5'd0};
      default: r = '{5'd7, 5'd9, 5'd0};
    endcase
    return r;
  endfunction

  // Function index to constant shift recipe.
  function automatic kmul_ent_t kmul_lut(input logic [FN_W-1:0] idx);
    kmul_ent_t r;
    case (idx)
      4'd0:  r = '{1'b1, 2'd0, 2'd0};  // 1
      4'd1:  r = '{1'b0, 2'd1, 2'd0};  // 2
      4'd2:  r = '{1'b1, 2'd1, 2'd0};  // 3
      4'd3:  r = '{1'b0, 2'd2, 2'd0};  // 4
      4'd4:  r = '{1'b1, 2'd2, 2'd0};  // 5
      4'd5:  r = '{1'b0, 2'd1, 2'd2};  // 6
      4'd6:  r = '{1'b1, 2'd1, 2'd2};  // 7
      4'd7:  r = '{1'b0, 2'd3, 2'd0};  // 8
      4'd8:  r = '{1'b1, 2'd3, 2'd0};  // 9
      4'd9:  r = '{1'b0, 2'd1, 2'd3};  // 10
      4'd10: r = '{1'b1, 2'd1, 2'd3};  // 11
      4'd11: r = '{1'b0, 2'd2, 2'd3};  // 12
      4'd12: r = '{1'b1, 2'd2, 2'd3};  // 13
      4'd13: r = '{1'b0, 2'd3, 2'd3};  // 16
      4'd14: r = '{1'b1, 2'd3, 2'd3};  // 17
      default: r = '{1'b0, 2'd0, 2'd0}; // 0
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cnv_add_tree.sv
module cnv_add_tree #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 32
) (
  input  logic [N-1:0][W-1:0] term_i,
  output logic [W-1:0]        sum_o
);

  localparam int unsigned NODES = 2 * N - 1;

  // Heap-ordered binary tree: leaves at N-1.., node i sums its two children.
  logic [W-1:0] node [NODES];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node[N-1+j] = term_i[j];
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_sum
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign sum_o = node[0];

endmodule

// File: rtl/cnv_term_gen.sv
module cnv_term_gen
  import cnv_pkg::*;
(
  input  cnv_mode_e                  mode_i,
  input  logic [FN_W-1:0]            fn_idx_i,
  input  word_t                      opnd_i,
  output word_t [N_TERMS-1:0]        term_o,
  output logic [FP_EXP_W-1:0]        exp_o,
  output logic                       kodd_o
);

  localparam int unsigned PAD_W = FRAC_W - FP_MAN_W;

  logic [FRAC_W-1:0] frac;
  shift_set_t        sh;
  kmul_ent_t         ke;

  function automatic word_t tap(input logic [FRAC_W-1:0] v, input logic [SH_W-1:0] s);
    return (s == '0) ? '0 : (word_t'(v) >> s);
  endfunction

  always_comb begin
    term_o = '0;
    exp_o  = '0;
    frac   = '0;
    sh     = '0;
    ke     = kmul_lut(fn_idx_i);
    kodd_o = ke.odd;
    case (mode_i)
      CM_LOG: begin
        frac      = {opnd_i[FP_MAN_W-1:0], {PAD_W{1'b0}}};
        sh        = log_seg_lut(opnd_i[FP_MAN_W-1 -: SEG_W]);
        term_o[0] = {opnd_i[WORD_W-2 -: FP_EXP_W] - FP_EXP_W'(FP_BIAS), frac};
        term_o[1] = tap(frac, sh.a);
        term_o[2] = tap(frac, sh.b);
        term_o[3] = tap(frac, sh.c);
      end
      CM_ALOG: begin
        frac      = opnd_i[FRAC_W-1:0];
        sh        = alog_seg_lut(frac[FRAC_W-1 -: SEG_W]);
        exp_o     = opnd_i[WORD_W-1 -: INT_W] + FP_EXP_W'(FP_BIAS);
        term_o[0] = word_t'(frac);
        term_o[1] = -tap(frac, sh.a);
        term_o[2] = -tap(frac, sh.b);
        term_o[3] = -tap(frac, sh.c);
      end
      CM_KMUL: begin
        term_o[0] = ke.odd ? opnd_i : '0;
        term_o[1] = (ke.p == '0) ? '0 : (opnd_i << ke.p);
        term_o[2] = (ke.q == '0) ? '0 : (opnd_i << ke.q);
      end
      default: begin
        term_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/cnv_lane.sv
module cnv_lane
  import cnv_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cnv_mode_e       mode_i,
  input  logic [FN_W-1:0] fn_idx_i,
  input  word_t           opnd_i,
  output word_t           res_o
);

  word_t [N_TERMS-1:0] terms;
  logic [FP_EXP_W-1:0] exp_f;
  logic                kodd;
  word_t               sum;
  word_t               corr;

  cnv_term_gen u_terms (
    .mode_i   (mode_i),
    .fn_idx_i (fn_idx_i),
    .opnd_i   (opnd_i),
    .term_o   (terms),
    .exp_o    (exp_f),
    .kodd_o   (kodd)
  );

  cnv_add_tree #(
    .N (N_TERMS),
    .W (WORD_W)
  ) u_tree (
    .term_i (terms),
    .sum_o  (sum)
  );

  always_comb begin
    case (mode_i)
      CM_ALOG: res_o = {1'b0, exp_f, sum[FRAC_W-1 -: FP_MAN_W]};
      default: res_o = sum;
    endcase
  end

  assign corr = sum - terms[0];

  AST_LOG_CORR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_LOG) |-> (corr <= word_t'(terms[0][FRAC_W-1:0]))); // R7

  AST_ALOG_NO_BORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_ALOG) |-> (sum[WORD_W-1:FRAC_W] == '0)); // R8

  AST_KMUL_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_KMUL && !kodd) |-> (res_o[0] == 1'b0)); // R5

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CM_RSVD) |-> (res_o == '0)); // R9

endmodule

// File: rtl/prog_cnv.sv
module prog_cnv
  import cnv_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [1:0]                mode_i,
  input  logic [FN_W-1:0]           fn_idx_i,
  input  logic [LANES*WORD_W-1:0]   opnd_i,
  output logic                      out_valid_o,
  output logic [LANES*WORD_W-1:0]   result_o
);

  localparam int unsigned BUS_W = LANES * WORD_W;

  cnv_mode_e          mode_e;
  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic [BUS_W-1:0]   lane_res;
  logic [BUS_W-1:0]   res_d, res_q;
  logic               vld_d, vld_q;

  assign mode_e = cnv_mode_e'(mode_i);

  // Reset asserts at once and deasserts two edges after rst_ni rises.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cnv_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_n_int),
      .mode_i   (mode_e),
      .fn_idx_i (fn_idx_i),
      .opnd_i   (opnd_i[l*WORD_W +: WORD_W]),
      .res_o    (lane_res[l*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    res_d = lane_res;
    vld_d = in_valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (in_valid_i) res_q <= res_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    in_valid_i |=> out_valid_o); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !in_valid_i |=> (!out_valid_o && $stable(result_o))); // R3

endmodule

// File: tb/tb_prog_cnv.sv
module tb_prog_cnv;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 20000;
  localparam real TOL       = 0.03125;
  localparam int NVEC       = 15;

  // {mode, fn_idx, operand (all lanes), expected (all lanes)}
  localparam logic [69:0] VECS [NVEC] = '{
    {2'b10, 4'd0,  32'h1234_5678, 32'h1234_5678},
    {2'b00, 4'd0,  32'h3F80_0000, 32'h0000_0000},
    {2'b10, 4'd2,  32'h0100_0000, 32'h0300_0000},
    {2'b01, 4'd0,  32'h0000_0000, 32'h3F80_0000},
    {2'b10, 4'd6,  32'hFF00_0000, 32'hF900_0000},
    {2'b00, 4'd0,  32'h4100_0000, 32'h0300_0000},
    {2'b11, 4'd3,  32'h1234_5678, 32'h0000_0000},
    {2'b01, 4'd0,  32'h0300_0000, 32'h4100_0000},
    {2'b10, 4'd12, 32'h0000_0001, 32'h0000_000D},
    {2'b00, 4'd0,  32'h3E80_0000, 32'hFE00_0000},
    {2'b10, 4'd13, 32'h0800_0000, 32'h8000_0000},
    {2'b01, 4'd0,  32'hFD00_0000, 32'h3E00_0000},
    {2'b10, 4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFEF},
    {2'b00, 4'd0,  32'hC080_0000, 32'h0200_0000},
    {2'b10, 4'd15, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   mode;
  logic [3:0]   fn_idx;
  logic [127:0] opnd;
  logic         out_valid;
  logic [127:0] result;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_cnv dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .mode_i      (mode),
    .fn_idx_i    (fn_idx),
    .opnd_i      (opnd),
    .out_valid_o (out_valid),
    .result_o    (result)
  );

  function automatic int kval(input int idx);
    if (idx <= 12) return idx + 1;
    if (idx == 13) return 16;
    if (idx == 14) return 17;
    return 0;
  endfunction

  function automatic real fp_to_real(input logic [31:0] b);
    int e;
    e = int'(b[30:23]);
    return (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** real'(e - 127));
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_tol(input string req, input real act, input real exp, input real err);
    total++;
    if (err > TOL || err < -TOL) begin
      bad++;
      $display("FAIL %s act=%f exp=%f", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] m, input logic [3:0] f,
                       input logic [127:0] op);
    in_valid = v;
    mode     = m;
    fn_idx   = f;
    opnd     = op;
    @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  initial begin
    logic [127:0] op;
    logic [127:0] held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mode     = 2'b00;
    fn_idx   = 4'd0;
    opnd     = '0;
    repeat (3) @(negedge clk);
    // R4: reset state
    check32("R4 valid in reset", {31'd0, out_valid}, 32'd0);
    check32("R4 result in reset", result[31:0] | result[127:96], 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check32("R4 valid after release", {31'd0, out_valid}, 32'd0);

    // R6 R2: stream the vector table back to back, mode changing every cycle
    for (int i = 0; i < NVEC; i++) begin
      drive(1'b1, VECS[i][69:68], VECS[i][67:64], {4{VECS[i][63:32]}});
      check32("R2 valid", {31'd0, out_valid}, 32'd1);
      for (int j = 0; j < 4; j++)
        check32("R6 vector", result[j*32 +: 32], VECS[i][31:0]);
    end

    // R1: distinct operands per lane, k = 5
    for (int j = 0; j < 4; j++) op[j*32 +: 32] = 32'h0101_0101 * (j + 1) + 32'(j * 977);
    drive(1'b1, 2'b10, 4'd4, op);
    for (int j = 0; j < 4; j++)
      check32("R1 lane independence", result[j*32 +: 32], op[j*32 +: 32] * 32'd5);

    // R3: idle cycles with changing inputs keep the result
    held = result;
    for (int c = 0; c < 3; c++) begin
      drive(1'b0, 2'(c), 4'(c + 7), ~op + 128'(c));
      check32("R3 valid low", {31'd0, out_valid}, 32'd0);
      check32("R3 held lane0", result[31:0], held[31:0]);
      check32("R3 held lane3", result[127:96], held[127:96]);
    end

    // R5: every function index, operands that overflow the word
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 4; j++) op[j*32 +: 32] = 32'h9E37_79B9 * 32'(i + 1) + 32'h1357_0000 * 32'(j);
      drive(1'b1, 2'b10, 4'(i), op);
      for (int j = 0; j < 4; j++)
        check32("R5 constant multiply", result[j*32 +: 32], op[j*32 +: 32] * 32'(kval(i)));
    end

    // R7: log sweep across segments and binades
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < 4; j++)
        op[j*32 +: 32] = {1'b0, 8'(100 + ((i * 7 + j * 13) % 50)), 23'(i * 1234567 + j * 7654321)};
      drive(1'b1, 2'b00, 4'(i), op);
      for (int j = 0; j < 4; j++) begin
        real act, exp_v;
        act   = real'($signed(result[j*32 +: 32])) / 16777216.0;
        exp_v = $ln(fp_to_real(op[j*32 +: 32])) / $ln(2.0);
        check_tol("R7 log", act, exp_v, act - exp_v);
      end
    end

    // R8: antilog sweep over negative and positive arguments
    for (int i = 0; i < 48; i++) begin
      for (int j = 0; j < 4; j++)
        op[j*32 +: 32] = 32'(((i * 4 + j) - 96) * 1048576 + (i * 40503 + j * 9973));
      drive(1'b1, 2'b01, 4'd0, op);
      for (int j = 0; j < 4; j++) begin
        real act, exp_v;
        act   = fp_to_real(result[j*32 +: 32]);
        exp_v = 2.0 ** (real'($signed(op[j*32 +: 32])) / 16777216.0);
        check_tol("R8 antilog", act, exp_v, act / exp_v - 1.0);
        check32("R8 sign", {31'd0, result[j*32+31]}, 32'd0);
      end
    end

    // R9: reserved mode with nonzero operands
    drive(1'b1, 2'b11, 4'd9, {4{32'hFFFF_FFFF}});
    check32("R9 reserved", result[63:32], 32'd0);

    // R4: asynchronous reset in the middle of a run
    drive(1'b1, 2'b10, 4'd1, {4{32'h0000_0040}});
    check32("R5 k2 before reset", result[31:0], 32'h0000_0080);
    #2 rst_n = 1'b0;
    #1;
    check32("R4 async result", result[31:0], 32'd0);
    check32("R4 async valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 2'b00, 4'd0, {4{32'h3F00_0000}});
    check32("R7 exact after reset", result[95:64], 32'hFF00_0000);

    report();
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

endmodule